// File: doc/BRIEF.md
# Dual-Input Gate Drive Interlock

This block sits between a PWM controller and the gate drivers of one half-bridge phase. The controller sends separate high-side and low-side commands, and the block returns one enable per switch. The block does not add dead time of its own. The controller keeps full control of edge placement, and the block only steps in when a command pattern would be unsafe.

The high-side path drops command pulses that are too short to drive the switch properly. It also enforces a minimum low interval before the high-side enable may rise again. A watchdog counts how long both synchronized commands have been high together. A short overlap passes through unchanged. Once the overlap outlasts its limit, only the high-side enable is cut, and it returns as soon as the overlap ends. A sticky flag records that a cut happened.

A supply-good input holds both enables low while the gate bias is not ready. Two temperature comparator flags drive a hysteresis latch that blocks only the high side. All time limits are parameters counted in clock cycles.

Top module: `gate_interlock`

## Requirements
- R1: While rst_ni is low, hs_gate_o, ls_gate_o and ovl_fault_o are all 0.
- R2: With supply good, ls_gate_o follows ls_cmd_i with a latency of 3 clock cycles on both edges.
- R3: With supply good, no temperature block and no overlap, hs_gate_o rises MIN_ON_CYC+2 cycles after hs_cmd_i rises and falls 3 cycles after hs_cmd_i falls.
- R4: A high-side command pulse shorter than MIN_ON_CYC cycles gives no hs_gate_o pulse. A pulse of exactly MIN_ON_CYC cycles gives a one-cycle hs_gate_o pulse.
- R5: Once hs_gate_o falls, it stays low for at least MIN_OFF_CYC cycles. With a command gap of G cycles, it rises max(G+MIN_ON_CYC+2, MIN_OFF_CYC+3) cycles after the command fell.
- R6: If both synchronized commands are high for more than OVL_CYC consecutive cycles, hs_gate_o is forced low. An overlap of exactly OVL_CYC cycles causes no cut, and OVL_CYC+1 cycles gives a one-cycle cut. ls_gate_o is never cut.
- R7: The cut lasts for the whole overlap however long that is, because the overlap counter saturates. hs_gate_o returns 3 cycles after ls_cmd_i falls, with no other action needed.
- R8: While supply_ok_i is low, both enables are 0 starting 3 cycles after it falls. They follow their commands again 3 cycles after it rises.
- R9: A temperature latch is set by temp_hot_i and cleared only by temp_cool_i. While it is set, hs_gate_o is 0 and ls_gate_o still follows its command. The latch affects the enables 4 cycles after a flag pulse.
- R10: ovl_fault_o rises one cycle after a cut begins and stays high until a one-cycle fault_clr_i strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_cmd_i | input | 1 | High-side PWM command (asynchronous) |
| ls_cmd_i | input | 1 | Low-side PWM command (asynchronous) |
| supply_ok_i | input | 1 | Gate bias supply is within specification |
| temp_hot_i | input | 1 | Temperature is above the trip point |
| temp_cool_i | input | 1 | Temperature is below the release point |
| fault_clr_i | input | 1 | Write-one strobe that clears ovl_fault_o |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| ovl_fault_o | output | 1 | Sticky flag: an overlap cut has occurred |

## Verification
Several properties are checked on every cycle by the assertions:
- the overlap counter never passes its limit;
- a cut always follows a cycle of overlap;
- a qualified high-side rise needs a high command in the cycle before;
- a qualified high-side fall is followed by at least one more low cycle;
- the temperature latch holds until the cool flag arrives;
- a missing supply or an active cut blocks the enables one cycle later;
- the fault flag holds until it is cleared.

Only the bench scenarios can show the exact latencies and the boundary cases. These are the pulse widths at MIN_ON_CYC-1 and MIN_ON_CYC, the overlap lengths at OVL_CYC and OVL_CYC+1, the re-arm timing after a short gap, a long overlap that tests saturation, and recovery after supply, temperature and overlap blocks.

// File: rtl/gate_interlock_pkg.sv
package gate_interlock_pkg;

  typedef struct packed {
    logic hs;
    logic ls;
    logic sup;
    logic hot;
    logic cool;
  } in_vec_t;

  function automatic int cnt_w(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/gi_sync.sv
module gi_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gi_hs_filter.sv
// Min on-time qualification and min off-time re-arm lockout for the high side.
module gi_hs_filter
  import gate_interlock_pkg::*;
#(
  parameter int MIN_ON  = 12,
  parameter int MIN_OFF = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic qual_o
);
  localparam int ON_W  = cnt_w(MIN_ON);
  localparam int OFF_W = cnt_w(MIN_OFF);
  localparam logic [ON_W-1:0]  ON_LIM  = ON_W'(MIN_ON - 1);
  localparam logic [OFF_W-1:0] OFF_LIM = OFF_W'(MIN_OFF);

  logic [ON_W-1:0]  on_cnt_q;
  logic [OFF_W-1:0] off_cnt_q;
  logic             qual_q;
  logic             rearm_ok;

  assign rearm_ok = (on_cnt_q >= ON_LIM) && (off_cnt_q >= OFF_LIM);
  assign qual_o   = in_i && (qual_q || rearm_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_cnt_q  <= '0;
      off_cnt_q <= OFF_LIM;
      qual_q    <= 1'b0;
    end else begin
      qual_q <= qual_o;
      if (!in_i)                  on_cnt_q <= '0;
      else if (on_cnt_q < ON_LIM) on_cnt_q <= on_cnt_q + 1'b1;
      if (qual_o)                    off_cnt_q <= '0;
      else if (off_cnt_q < OFF_LIM)  off_cnt_q <= off_cnt_q + 1'b1;
    end
  end

  // R4: a qualified rise needs the command high in the previous cycle
  a_r4_rise_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qual_o) |-> $past(in_i));

  // R5: a qualified fall is followed by at least one more low cycle
  a_r5_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(qual_o) |=> !qual_o);
endmodule

// File: rtl/gi_overlap_watch.sv
module gi_overlap_watch
  import gate_interlock_pkg::*;
#(
  parameter int OVL = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_i,
  input  logic ls_i,
  output logic cut_o
);
  localparam int CW = cnt_w(OVL);
  localparam logic [CW-1:0] LIM = CW'(OVL);

  logic [CW-1:0] cnt_q;
  logic          both;

  assign both  = hs_i && ls_i;
  assign cut_o = both && (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!both)       cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  a_r7_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  a_r6_cut_after_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut_o |-> $past(both));
endmodule

// File: rtl/gi_temp_latch.sv
module gi_temp_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic cool_i,
  output logic hot_o
);
  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hot_q <= 1'b0;
    else if (hot_i)  hot_q <= 1'b1;
    else if (cool_i) hot_q <= 1'b0;
  end

  assign hot_o = hot_q;

  a_r9_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_q && !cool_i |=> hot_q);
endmodule

// File: rtl/gate_interlock.sv
module gate_interlock
  import gate_interlock_pkg::*;
#(
  parameter int MIN_ON_CYC  = 12,
  parameter int MIN_OFF_CYC = 17,
  parameter int OVL_CYC     = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_cmd_i,
  input  logic ls_cmd_i,
  input  logic supply_ok_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  input  logic fault_clr_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic ovl_fault_o
);
  localparam int SW = $bits(in_vec_t);

  in_vec_t raw, syn;
  logic    hs_qual, cut, hot;
  logic    hs_gate_q, ls_gate_q, fault_q;

  assign raw = '{hs: hs_cmd_i, ls: ls_cmd_i, sup: supply_ok_i,
                 hot: temp_hot_i, cool: temp_cool_i};

  gi_sync #(.W(SW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  gi_hs_filter #(.MIN_ON(MIN_ON_CYC), .MIN_OFF(MIN_OFF_CYC)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (syn.hs),
    .qual_o(hs_qual)
  );

  gi_overlap_watch #(.OVL(OVL_CYC)) u_ovl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hs_i  (syn.hs),
    .ls_i  (syn.ls),
    .cut_o (cut)
  );

  gi_temp_latch u_temp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hot_i (syn.hot),
    .cool_i(syn.cool),
    .hot_o (hot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_gate_q <= 1'b0;
      ls_gate_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      hs_gate_q <= syn.sup && !hot && !cut && hs_qual;
      ls_gate_q <= syn.sup && syn.ls;
      if (cut)              fault_q <= 1'b1;  // set wins over clear
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end

  assign hs_gate_o   = hs_gate_q;
  assign ls_gate_o   = ls_gate_q;
  assign ovl_fault_o = fault_q;

  a_r8_no_supply_no_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn.sup |=> !hs_gate_q && !ls_gate_q);

  a_r6_cut_blocks_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut |=> !hs_gate_q);

  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && !fault_clr_i |=> fault_q);
endmodule

// File: tb/gate_interlock_bench.sv
module gate_interlock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_ON     = 12;
  localparam int MIN_OFF    = 17;
  localparam int OVL        = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hs_cmd = 1'b0, ls_cmd = 1'b0, sup_ok = 1'b0;
  logic t_hot = 1'b0, t_cool = 1'b0, f_clr = 1'b0;
  logic hs_gate, ls_gate, fault;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_interlock #(.MIN_ON_CYC(MIN_ON), .MIN_OFF_CYC(MIN_OFF), .OVL_CYC(OVL)) u_gate_interlock (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .hs_cmd_i   (hs_cmd),
    .ls_cmd_i   (ls_cmd),
    .supply_ok_i(sup_ok),
    .temp_hot_i (t_hot),
    .temp_cool_i(t_cool),
    .fault_clr_i(f_clr),
    .hs_gate_o  (hs_gate),
    .ls_gate_o  (ls_gate),
    .ovl_fault_o(fault)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 hs_gate in reset", hs_gate, 0);
    chk("R1 ls_gate in reset", ls_gate, 0);
    chk("R1 fault in reset", fault, 0);
    sup_ok = 1'b1;
    rst_ni = 1'b1;
    step(10);
  endtask

  task automatic t_ls_follow();
    ls_cmd = 1'b1;
    step(2); chk("R2 ls rise early", ls_gate, 0);
    step(1); chk("R2 ls rise", ls_gate, 1);
    ls_cmd = 1'b0;
    step(2); chk("R2 ls fall early", ls_gate, 1);
    step(1); chk("R2 ls fall", ls_gate, 0);
    step(5);
  endtask

  task automatic t_hs_latency();
    hs_cmd = 1'b1;
    step(MIN_ON + 1); chk("R3 hs rise early", hs_gate, 0);
    step(1);          chk("R3 hs rise", hs_gate, 1);
    step(10);
    hs_cmd = 1'b0;
    step(2); chk("R3 hs fall early", hs_gate, 1);
    step(1); chk("R3 hs fall", hs_gate, 0);
    step(30);
  endtask

  task automatic t_min_on();
    int highs;
    hs_cmd = 1'b1; step(MIN_ON - 1); hs_cmd = 1'b0;
    highs = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (hs_gate) highs++; end
    chk("R4 short pulse suppressed", highs, 0);
    step(10);
    hs_cmd = 1'b1; step(MIN_ON); hs_cmd = 1'b0;
    highs = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (hs_gate) highs++; end
    chk("R4 min pulse passes", highs, 1);
    step(20);
  endtask

  task automatic t_min_off(input int gap);
    int rise;
    rise = ((gap + MIN_ON + 2) > (MIN_OFF + 3)) ? (gap + MIN_ON + 2) : (MIN_OFF + 3);
    hs_cmd = 1'b1; step(30);
    hs_cmd = 1'b0; step(gap);
    hs_cmd = 1'b1;
    step(rise - 1 - gap); chk("R5 rearm early", hs_gate, 0);
    step(1);              chk("R5 rearm", hs_gate, 1);
    hs_cmd = 1'b0; step(30);
  endtask

  task automatic t_overlap_short();
    int lows;
    hs_cmd = 1'b1; step(20);
    ls_cmd = 1'b1; step(OVL); ls_cmd = 1'b0;
    lows = 0;
    for (int i = 0; i < 40; i++) begin step(1); if (!hs_gate) lows++; end
    chk("R6 overlap at limit no cut", lows, 0);
    chk("R10 no fault at limit", fault, 0);
    ls_cmd = 1'b1; step(OVL + 1); ls_cmd = 1'b0;
    lows = 0;
    for (int i = 0; i < 40; i++) begin step(1); if (!hs_gate) lows++; end
    chk("R6 overlap limit+1 one-cycle cut", lows, 1);
    chk("R10 fault set", fault, 1);
    f_clr = 1'b1; step(1); f_clr = 1'b0;
    chk("R10 fault cleared", fault, 0);
    hs_cmd = 1'b0; step(30);
  endtask

  task automatic t_overlap_cut();
    int highs;
    hs_cmd = 1'b1; step(20);
    ls_cmd = 1'b1;
    step(OVL + 2); chk("R6 hs before cut", hs_gate, 1);
    chk("R10 fault before cut", fault, 0);
    step(1);       chk("R6 hs cut", hs_gate, 0);
    chk("R6 ls not cut", ls_gate, 1);
    chk("R10 fault after cut", fault, 1);
    highs = 0;
    for (int i = 0; i < 70; i++) begin step(1); if (hs_gate) highs++; end
    chk("R7 cut held through long overlap", highs, 0);
    ls_cmd = 1'b0;
    step(2); chk("R7 hs still cut", hs_gate, 0);
    step(1); chk("R7 hs resumes", hs_gate, 1);
    step(20);
    chk("R10 fault sticky", fault, 1);
    f_clr = 1'b1; step(1); f_clr = 1'b0;
    chk("R10 fault cleared by strobe", fault, 0);
    step(5);
    chk("R10 fault stays clear", fault, 0);
    hs_cmd = 1'b0; step(30);
  endtask

  task automatic t_supply();
    hs_cmd = 1'b1; step(20);
    sup_ok = 1'b0;
    step(2); chk("R8 hs before drop", hs_gate, 1);
    step(1); chk("R8 hs dropped", hs_gate, 0);
    step(5);
    sup_ok = 1'b1;
    step(2); chk("R8 hs before return", hs_gate, 0);
    step(1); chk("R8 hs returns", hs_gate, 1);
    hs_cmd = 1'b0; step(30);
    sup_ok = 1'b0; step(5);
    ls_cmd = 1'b1; step(5);
    chk("R8 ls held without supply", ls_gate, 0);
    sup_ok = 1'b1;
    step(2); chk("R8 ls before return", ls_gate, 0);
    step(1); chk("R8 ls returns", ls_gate, 1);
    ls_cmd = 1'b0; step(10);
  endtask

  task automatic t_temp();
    hs_cmd = 1'b1; step(20);
    t_hot = 1'b1; step(1); t_hot = 1'b0;
    step(2); chk("R9 hs before trip", hs_gate, 1);
    step(1); chk("R9 hs tripped", hs_gate, 0);
    step(20); chk("R9 trip held", hs_gate, 0);
    hs_cmd = 1'b0; step(5);
    ls_cmd = 1'b1; step(3);
    chk("R9 ls follows while hot", ls_gate, 1);
    ls_cmd = 1'b0; step(3);
    chk("R9 ls off while hot", ls_gate, 0);
    step(20);
    hs_cmd = 1'b1; step(20);
    chk("R9 hs blocked while hot", hs_gate, 0);
    t_cool = 1'b1; step(1); t_cool = 1'b0;
    step(2); chk("R9 hs before release", hs_gate, 0);
    step(1); chk("R9 hs released", hs_gate, 1);
    hs_cmd = 1'b0; step(30);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ls_follow();
    t_hs_latency();
    t_min_on();
    t_min_off(2);
    t_min_off(8);
    t_overlap_short();
    t_overlap_cut();
    t_supply();
    t_temp();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule